// File: doc/BRIEF.md
# Two-Wire Controller Command Register Decoder

This block decodes a 32-bit write-only command register for a two-wire serial controller. A simple write port presents an address, a data word and a write strobe. When a write hits the register address, it has two kinds of effect. Persistent mode flags change through pairs of set and clear bits. Single-cycle command strobes go out to the serial engine, the FIFOs and the reset logic. Writing a 0 to any bit does nothing, so software changes only the functions whose bits it writes as 1.

There are seven persistent flags: host mode, client mode, high-speed mode, SMBus mode, packet error checking, alternative command mode and FIFO use. In each pair the clear bit takes priority: an enable acts only when its own clear bit is 0 in the same write. The strobes request a START, a STOP, an SMBus quick command, a bus clear, a PEC transfer, a transmit FIFO flush, a receive FIFO flush, a transmit FIFO unlock and a soft reset. The quick command and bus clear strobes are suppressed unless host mode is already on. The soft reset returns every flag to 0. A write-protect input blocks every write. Turning a mode off only raises a request by clearing the flag; draining the engine gracefully is left to the engine.

Top module: `tw_cmd_decode`

## Requirements
- R1: After synchronous reset, all seven mode flags and all nine strobes are 0.
- R2: A write takes effect only when `wr_en` is 1 and `wr_addr` equals `REG_OFFSET` (default byte address 0x600); a write to any other address changes no flag and raises no strobe.
- R3: While `wprot` is 1, writes change no flag and raise no strobe.
- R4: An accepted write with an enable bit at 1 and its clear bit at 0 sets that flag in the next cycle. A bit written as 0 leaves its flag unchanged. The enable/clear bit positions are: host 2/3, client 4/5, high-speed 8/9, SMBus 10/11, PEC 12/13, alternative command 16/17, FIFO 28/29.
- R5: An accepted write with a clear bit at 1 clears its flag, also when the matching enable bit is 1 in the same write.
- R6: An accepted write raises a strobe in the next cycle for each of these bits written as 1: START bit 0, STOP bit 1, PEC request bit 14, transmit FIFO flush bit 24, receive FIFO flush bit 25, transmit FIFO unlock bit 26.
- R7: The quick command strobe (bit 6) and the bus clear strobe (bit 15) are raised only if the host flag was 1 before the write.
- R8: An accepted write with bit 7 set raises `soft_rst_p`, clears every flag, and suppresses every other effect of that write.
- R9: Each strobe is high for exactly the cycle after the accepted write that requested it; back-to-back writes give back-to-back single pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data, command bits |
| wprot | input | 1 | Write protect: blocks all writes when 1 |
| host_en | output | 1 | Host mode flag |
| client_en | output | 1 | Client mode flag |
| hs_en | output | 1 | High-speed mode flag |
| smb_en | output | 1 | SMBus mode flag |
| pec_en | output | 1 | Packet error checking flag |
| altcmd_en | output | 1 | Alternative command mode flag |
| fifo_en | output | 1 | FIFO use flag |
| start_p | output | 1 | START request strobe |
| stop_p | output | 1 | STOP request strobe |
| quick_p | output | 1 | SMBus quick command strobe |
| bus_clr_p | output | 1 | Bus clear strobe |
| pec_req_p | output | 1 | PEC transfer request strobe |
| txf_clr_p | output | 1 | Transmit FIFO flush strobe |
| rxf_clr_p | output | 1 | Receive FIFO flush strobe |
| txf_lock_clr_p | output | 1 | Transmit FIFO unlock strobe |
| soft_rst_p | output | 1 | Soft reset strobe |

## Verification
The assertions assume `wr_en`, `wr_addr`, `wr_data` and `wprot` are steady around each rising edge. They also assume that the cycle before any check is not itself in reset, which is why every property is disabled during reset. The bench meets these assumptions by changing inputs only on falling edges. It releases reset on a falling edge and holds `wr_en` for exactly one clock per write, except in the back-to-back case, where it deliberately holds `wr_en` for two clocks with different data.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int CMD_W  = 32;
  localparam int N_MODE = 7;
  localparam int N_STB  = 9;

  // mode flag index: host, client, high-speed, smbus, pec, alt command, fifo
  localparam int EN_POS  [N_MODE] = '{2, 4, 8, 10, 12, 16, 28};
  localparam int DIS_POS [N_MODE] = '{3, 5, 9, 11, 13, 17, 29};

  // strobe index
  localparam int S_START = 0;
  localparam int S_STOP  = 1;
  localparam int S_QUICK = 2;
  localparam int S_BCLR  = 3;
  localparam int S_PECRQ = 4;
  localparam int S_TXF   = 5;
  localparam int S_RXF   = 6;
  localparam int S_TXFL  = 7;
  localparam int S_SOFT  = 8;

  // strobe source bit positions in the data word, by strobe index
  localparam int STB_POS [N_STB] = '{0, 1, 6, 15, 14, 24, 25, 26, 7};
endpackage

// File: rtl/twc_addr_match.sv
module twc_addr_match #(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h600
) (
  input  logic              wr_en,
  input  logic              wprot,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit
);
  always_comb hit = wr_en && !wprot && (wr_addr == REG_OFFSET);
endmodule

// File: rtl/twc_mode_flag.sv
module twc_mode_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic soft_clr,
  input  logic set_bit,
  input  logic clr_bit,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (hit) begin
      if (soft_clr || clr_bit) q <= 1'b0;
      else if (set_bit)        q <= 1'b1;
    end
  end
endmodule

// File: rtl/twc_strobe_gen.sv
module twc_strobe_gen
  import twc_pkg::*;
#(
  parameter int NS = N_STB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          host_q,
  input  logic [NS-1:0] req,
  output logic [NS-1:0] pulse
);
  localparam logic [NS-1:0] SOFT_MASK = NS'(1) << S_SOFT;
  localparam logic [NS-1:0] HOST_MASK = (NS'(1) << S_QUICK) | (NS'(1) << S_BCLR);

  logic [NS-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (hit) begin
      if (req[S_SOFT]) begin
        nxt = SOFT_MASK;
      end else begin
        nxt = req & ~SOFT_MASK;
        if (!host_q) nxt = nxt & ~HOST_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= '0;
    else     pulse <= nxt;
  end
endmodule

// File: rtl/tw_cmd_decode.sv
module tw_cmd_decode
  import twc_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              wprot,
  output logic              host_en,
  output logic              client_en,
  output logic              hs_en,
  output logic              smb_en,
  output logic              pec_en,
  output logic              altcmd_en,
  output logic              fifo_en,
  output logic              start_p,
  output logic              stop_p,
  output logic              quick_p,
  output logic              bus_clr_p,
  output logic              pec_req_p,
  output logic              txf_clr_p,
  output logic              rxf_clr_p,
  output logic              txf_lock_clr_p,
  output logic              soft_rst_p
);
  logic              hit;
  logic              soft_req;
  logic [N_MODE-1:0] mode_q;
  logic [N_STB-1:0]  stb_req;
  logic [N_STB-1:0]  stb_q;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[31:30], wr_data[27], wr_data[23:18]};

  twc_addr_match #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_match (
    .wr_en  (wr_en),
    .wprot  (wprot),
    .wr_addr(wr_addr),
    .hit    (hit)
  );

  assign soft_req = wr_data[STB_POS[S_SOFT]];

  for (genvar m = 0; m < N_MODE; m++) begin : g_mode
    twc_mode_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit),
      .soft_clr(soft_req),
      .set_bit (wr_data[EN_POS[m]]),
      .clr_bit (wr_data[DIS_POS[m]]),
      .q       (mode_q[m])
    );
  end

  for (genvar s = 0; s < N_STB; s++) begin : g_req
    assign stb_req[s] = wr_data[STB_POS[s]];
  end

  twc_strobe_gen #(.NS(N_STB)) u_stb (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .host_q(mode_q[0]),
    .req   (stb_req),
    .pulse (stb_q)
  );

  assign host_en   = mode_q[0];
  assign client_en = mode_q[1];
  assign hs_en     = mode_q[2];
  assign smb_en    = mode_q[3];
  assign pec_en    = mode_q[4];
  assign altcmd_en = mode_q[5];
  assign fifo_en   = mode_q[6];

  assign start_p        = stb_q[S_START];
  assign stop_p         = stb_q[S_STOP];
  assign quick_p        = stb_q[S_QUICK];
  assign bus_clr_p      = stb_q[S_BCLR];
  assign pec_req_p      = stb_q[S_PECRQ];
  assign txf_clr_p      = stb_q[S_TXF];
  assign rxf_clr_p      = stb_q[S_RXF];
  assign txf_lock_clr_p = stb_q[S_TXFL];
  assign soft_rst_p     = stb_q[S_SOFT];
endmodule

// File: rtl/tw_cmd_decode_chk.sv
module tw_cmd_decode_chk #(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h600
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wprot,
  input logic              host_en,
  input logic              client_en,
  input logic              hs_en,
  input logic              smb_en,
  input logic              pec_en,
  input logic              altcmd_en,
  input logic              fifo_en,
  input logic              start_p,
  input logic              stop_p,
  input logic              quick_p,
  input logic              bus_clr_p,
  input logic              pec_req_p,
  input logic              txf_clr_p,
  input logic              rxf_clr_p,
  input logic              txf_lock_clr_p,
  input logic              soft_rst_p
);
  logic       acc;
  logic [6:0] modes;
  logic [7:0] others;

  assign acc    = wr_en && !wprot && (wr_addr == REG_OFFSET);
  assign modes  = {fifo_en, altcmd_en, pec_en, smb_en, hs_en, client_en, host_en};
  assign others = {txf_lock_clr_p, rxf_clr_p, txf_clr_p, pec_req_p,
                   bus_clr_p, quick_p, stop_p, start_p};

  // R3
  wprot_block_chk: assert property (@(posedge clk) disable iff (rst)
    wprot |=> ($stable(modes) && !soft_rst_p && others == 8'h00));

  // R4
  host_set_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_data[2] && !wr_data[3] && !wr_data[7]) |=> host_en);

  // R5
  smb_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_data[11]) |=> !smb_en);

  // R7
  host_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !host_en |=> (!quick_p && !bus_clr_p));

  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_p |-> (modes == 7'h00 && others == 8'h00));

  // R9
  start_once_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc && wr_data[0]) |=> !start_p);
endmodule

bind tw_cmd_decode tw_cmd_decode_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (.*);

// File: tb/tw_cmd_decode_bench.sv
module tw_cmd_decode_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wprot = 1'b0;
  logic host_en, client_en, hs_en, smb_en, pec_en, altcmd_en, fifo_en;
  logic start_p, stop_p, quick_p, bus_clr_p, pec_req_p;
  logic txf_clr_p, rxf_clr_p, txf_lock_clr_p, soft_rst_p;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tw_cmd_decode u_tw_cmd_decode (.*);

  // packing: {fifo, altcmd, pec, smb, hs, client, host}
  function automatic logic [6:0] flags();
    return {fifo_en, altcmd_en, pec_en, smb_en, hs_en, client_en, host_en};
  endfunction
  // packing: {soft, txf_lock, rxf, txf, pec_req, bus_clr, quick, stop, start}
  function automatic logic [8:0] stbs();
    return {soft_rst_p, txf_lock_clr_p, rxf_clr_p, txf_clr_p, pec_req_p,
            bus_clr_p, quick_p, stop_p, start_p};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives one write, returns at the falling edge after the capturing edge
  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    check("R1 flags", 16'(flags()), 16'h0);
    check("R1 strobes", 16'(stbs()), 16'h0);
  endtask

  task automatic t_enable();
    do_write(12'h600, (32'd1<<2)|(32'd1<<8)|(32'd1<<12)|(32'd1<<28));
    check("R4 set", 16'(flags()), 16'b1010101);
    check("R4 no strobe", 16'(stbs()), 16'h0);
    do_write(12'h600, 32'h0);
    check("R4 zero write", 16'(flags()), 16'b1010101);
  endtask

  task automatic t_disable();
    do_write(12'h600, (32'd1<<9)|(32'd3<<10)|(32'd3<<16)|(32'd1<<4));
    check("R5 clear wins", 16'(flags()), 16'b1010011);
    do_write(12'h600, 32'd1<<10);
    check("R4 smb set", 16'(flags()), 16'b1011011);
  endtask

  task automatic t_strobes();
    do_write(12'h600, 32'h1 | 32'h2 | (32'd1<<6) | (32'd1<<14) | (32'd1<<15) |
                      (32'd7<<24));
    check("R6 R7 strobes", 16'(stbs()), 16'b011111111);
    check("R6 flags kept", 16'(flags()), 16'b1011011);
    @(negedge clk);
    check("R9 drop", 16'(stbs()), 16'h0);
  endtask

  task automatic t_host_gate();
    do_write(12'h600, 32'd1<<3);
    check("R5 host off", 16'(flags()), 16'b1011010);
    do_write(12'h600, 32'h1 | (32'd1<<6) | (32'd1<<15));
    check("R7 gated", 16'(stbs()), 16'b000000001);
  endtask

  task automatic t_addr();
    do_write(12'h604, 32'h1 | (32'd1<<11));
    check("R2 flags", 16'(flags()), 16'b1011010);
    check("R2 strobes", 16'(stbs()), 16'h0);
  endtask

  task automatic t_wprot();
    wprot = 1'b1;
    do_write(12'h600, 32'h1 | (32'd1<<7) | (32'd1<<11));
    check("R3 flags", 16'(flags()), 16'b1011010);
    check("R3 strobes", 16'(stbs()), 16'h0);
    wprot = 1'b0;
  endtask

  task automatic t_soft();
    do_write(12'h600, 32'h1 | (32'd1<<7) | (32'd1<<2));
    check("R8 strobe", 16'(stbs()), 16'b100000000);
    check("R8 flags", 16'(flags()), 16'h0);
    @(negedge clk);
    check("R9 soft drop", 16'(stbs()), 16'h0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'h600; wr_data = 32'h1;
    @(negedge clk);
    check("R9 first", 16'(stbs()), 16'b000000001);
    wr_data = 32'h2;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check("R9 second", 16'(stbs()), 16'b000000010);
    @(negedge clk);
    check("R9 idle", 16'(stbs()), 16'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_disable();
        t_strobes();
        t_host_gate();
        t_addr();
        t_wprot();
        t_soft();
        t_back_to_back();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule